// File: doc/BRIEF.md
# Read/Write Turnaround Scheduler

This block is the mode controller of a DRAM command multiplexer. It keeps the command path in one of two data directions, reading or writing. It tells the command choosers which kinds of command they may pick, and it tells each command phase which source to steer onto the bus. It changes direction only after the bus has had time to turn around. The two turnaround gaps come from PHY parameters. In the read-to-write direction the gap covers the read latency. In the write-to-read direction it covers the write recovery time, the write latency rounded up to whole controller cycles, and the column spacing.

When both directions have work queued, a hold timer for each direction caps how long the current direction is kept, so neither side is starved. Two spacing counters gate the choosers. One enforces the minimum distance between row activations. The other enforces the minimum distance between column commands. A refresh request is passed on to every bank. The refresh slot is taken only once every bank has granted it, and the scheduler then returns to the read direction.

Top module: `rw_turn_sched`

## Requirements
- R1: After reset the block is in read mode. The per-phase select bus `steer` carries 2 bits per phase at bits [2p+1:2p], coded 0 = idle, 1 = command chooser, 2 = column chooser, 3 = refresh. In read mode phase RD_PHASE carries 2 and phase RDCMD_PHASE carries 1. `want_rd` and `want_cmd` are 1, `want_wr` is 0, and `ref_issue` and `ref_ask` are 0.
- R2: In read mode, when `wr_avail` is high and either `rd_avail` is low or the read hold has expired, the next cycle starts a turnaround. During the turnaround every phase carries 0, and `want_rd`, `want_wr`, `want_cmd` and `want_act` are all 0. This lasts READ_LAT-1 cycles (at least 1), and write mode appears on the following cycle.
- R3: The turnaround from write mode to read mode lasts T_WTR + ceil(CWL/NPHASES) + T_CCD - 1 idle cycles (at least 1). Read mode appears on the following cycle.
- R4: When both directions are pending, write mode is kept for exactly WRITE_HOLD cycles before its turnaround starts.
- R5: When both directions are pending, read mode is kept for exactly READ_HOLD cycles after each entry. The read hold starts out expired after reset, so the first read-to-write change is immediate.
- R6: A cycle with `act_accept` high closes `want_act` for the next T_RRD-1 cycles. It reopens on the T_RRD-th cycle. A T_RRD of 0 or 1 never closes it.
- R7: A cycle with `col_accept` high closes `want_rd` and `want_wr` for the next T_CCD-1 cycles. They reopen on the T_CCD-th cycle. A T_CCD of 0 or 1 never closes them.
- R8: Every bit of `ref_ask` equals `ref_pending` in the same cycle.
- R9: While `ref_pending` is high and any bit of `ref_grant` is low, `ref_issue` stays 0 and the mode does not change. In the cycle after all grants are high, `ref_issue` is 1 for exactly one cycle. During that cycle phase 0 carries 3, the other phases carry 0, and all want outputs are 0. Read mode follows.
- R10: In write mode phase WR_PHASE carries 2 and phase WRCMD_PHASE carries 1. `want_wr` and `want_cmd` are 1 and `want_rd` is 0. `want_rd` and `want_wr` are never 1 together.
- R11: Read mode is kept indefinitely while `wr_avail` is low. Write mode is kept indefinitely while `rd_avail` is low. This holds even after the hold time has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_avail | input | 1 | Some bank has a read pending |
| wr_avail | input | 1 | Some bank has a write pending |
| ref_pending | input | 1 | Refresher asks for a refresh slot |
| ref_grant | input | NBANKS | Per-bank permission to refresh |
| act_accept | input | 1 | An activate was taken this cycle |
| col_accept | input | 1 | A read or write column command was taken this cycle |
| want_rd | output | 1 | Column chooser may pick reads |
| want_wr | output | 1 | Column chooser may pick writes |
| want_cmd | output | 1 | Command chooser may pick non-column commands |
| want_act | output | 1 | Activates are allowed |
| ref_ask | output | NBANKS | Refresh request broadcast to every bank |
| ref_issue | output | 1 | Refresh command slot is open this cycle |
| steer | output | 2*NPHASES | Per-phase source select, 2 bits per phase |

## Verification
A wrong mode register shows up at once on `steer`, because each mode has its own select pattern and turnarounds are all idle. An off-by-one in a turnaround or hold counter moves the first changed pattern by one cycle. The bench therefore checks every cycle across each transition rather than only the endpoints. A spacing counter that reloads wrongly shows on `want_act` or `want_rd` in the first cycle after the accept, or in the cycle it should reopen. A refresh gate that ignores one bank raises `ref_issue` one cycle after that bank's grant is still missing.

// File: rtl/rw_turn_pkg.sv
package rw_turn_pkg;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_RTW   = 3'd1,
    ST_WRITE = 3'd2,
    ST_WTR   = 3'd3,
    ST_REF   = 3'd4
  } mode_e;

  // per-phase source selects; the steering mux decodes these values
  localparam logic [1:0] SEL_IDLE = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_COL  = 2'd2;
  localparam logic [1:0] SEL_REF  = 2'd3;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // idle cycles between the last read-mode cycle and the first write-mode cycle
  function automatic int rtw_idle(input int read_lat);
    return (read_lat > 1) ? read_lat - 1 : 1;
  endfunction

  // idle cycles between the last write-mode cycle and the first read-mode cycle
  function automatic int wtr_idle(input int twtr, input int cwl, input int nph, input int tccd);
    int g;
    g = twtr + ceil_div(cwl, nph) + tccd - 1;
    return (g < 1) ? 1 : g;
  endfunction

  function automatic int bits_for(input int maxval);
    int b;
    b = $clog2(maxval + 1);
    return (b < 1) ? 1 : b;
  endfunction

endpackage

// File: rtl/cmd_spacing.sv
module cmd_spacing #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic open_o
);
  import rw_turn_pkg::*;

  localparam int CW = bits_for(GAP);
  localparam logic [CW-1:0] LOADV = (GAP > 1) ? CW'(GAP - 1) : '0;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= LOADV;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign open_o = (cnt == '0);

  generate
    if (GAP > 1) begin : g_chk
      // R6/R7: an accepted command closes the window on the next cycle
      p_gap_closes_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !open_o);
    end
  endgenerate

endmodule

// File: rtl/mode_hold_timer.sv
module mode_hold_timer #(
  parameter int HOLD          = 16,
  parameter bit START_EXPIRED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  import rw_turn_pkg::*;

  localparam int HW = bits_for(HOLD);
  localparam logic [HW-1:0] TOP = (HOLD > 1) ? HW'(HOLD - 1) : '0;
  localparam logic [HW-1:0] INIT = START_EXPIRED ? '0 : TOP;

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= INIT;
    else if (!active)    cnt <= TOP;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/phase_steer.sv
module phase_steer #(
  parameter int NPHASES     = 2,
  parameter int RD_PHASE    = 0,
  parameter int RDCMD_PHASE = 1,
  parameter int WR_PHASE    = 1,
  parameter int WRCMD_PHASE = 0
) (
  input  rw_turn_pkg::mode_e    mode,
  output logic [2*NPHASES-1:0]  steer
);
  import rw_turn_pkg::*;

  always_comb begin
    steer = '0;
    for (int p = 0; p < NPHASES; p++) begin
      unique case (mode)
        ST_READ: begin
          if (p == RD_PHASE)    steer[2*p +: 2] = SEL_COL;
          if (p == RDCMD_PHASE) steer[2*p +: 2] = SEL_CMD;
        end
        ST_WRITE: begin
          if (p == WR_PHASE)    steer[2*p +: 2] = SEL_COL;
          if (p == WRCMD_PHASE) steer[2*p +: 2] = SEL_CMD;
        end
        ST_REF: begin
          if (p == 0)           steer[2*p +: 2] = SEL_REF;
        end
        default:                steer[2*p +: 2] = SEL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rw_turn_sched.sv
module rw_turn_sched #(
  parameter int NBANKS      = 8,
  parameter int NPHASES     = 2,
  parameter int RD_PHASE    = 0,
  parameter int RDCMD_PHASE = 1,
  parameter int WR_PHASE    = 1,
  parameter int WRCMD_PHASE = 0,
  parameter int READ_LAT    = 5,
  parameter int CWL         = 3,
  parameter int T_WTR       = 2,
  parameter int T_CCD       = 1,
  parameter int T_RRD       = 0,
  parameter int READ_HOLD   = 32,
  parameter int WRITE_HOLD  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_avail,
  input  logic                 wr_avail,
  input  logic                 ref_pending,
  input  logic [NBANKS-1:0]    ref_grant,
  input  logic                 act_accept,
  input  logic                 col_accept,
  output logic                 want_rd,
  output logic                 want_wr,
  output logic                 want_cmd,
  output logic                 want_act,
  output logic [NBANKS-1:0]    ref_ask,
  output logic                 ref_issue,
  output logic [2*NPHASES-1:0] steer
);
  import rw_turn_pkg::*;

  localparam int RTW_N = rtw_idle(READ_LAT);
  localparam int WTR_N = wtr_idle(T_WTR, CWL, NPHASES, T_CCD);
  localparam int TMAX  = (RTW_N > WTR_N) ? RTW_N : WTR_N;
  localparam int TW    = bits_for(TMAX);
  localparam logic [TW-1:0] RTW_LOAD = TW'(RTW_N - 1);
  localparam logic [TW-1:0] WTR_LOAD = TW'(WTR_N - 1);

  mode_e state, state_nx;
  logic [TW-1:0] tcnt;

  // named internal events
  logic go_ref, turn_done, rd_exp, wr_exp, rrd_open, ccd_open;
  logic in_rd, in_wr, leave_rd, leave_wr;

  assign go_ref    = ref_pending & (&ref_grant);
  assign turn_done = (tcnt == '0);
  assign in_rd     = (state == ST_READ);
  assign in_wr     = (state == ST_WRITE);
  assign leave_rd  = wr_avail & (~rd_avail | rd_exp);
  assign leave_wr  = rd_avail & (~wr_avail | wr_exp);

  mode_hold_timer #(.HOLD(READ_HOLD), .START_EXPIRED(1'b1)) u_rd_hold (
    .clk(clk), .rst_n(rst_n), .active(in_rd), .expired(rd_exp));

  mode_hold_timer #(.HOLD(WRITE_HOLD), .START_EXPIRED(1'b0)) u_wr_hold (
    .clk(clk), .rst_n(rst_n), .active(in_wr), .expired(wr_exp));

  cmd_spacing #(.GAP(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .fire(act_accept), .open_o(rrd_open));

  cmd_spacing #(.GAP(T_CCD)) u_ccd (
    .clk(clk), .rst_n(rst_n), .fire(col_accept), .open_o(ccd_open));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_READ: begin
        if (go_ref)        state_nx = ST_REF;
        else if (leave_rd) state_nx = ST_RTW;
      end
      ST_WRITE: begin
        if (go_ref)        state_nx = ST_REF;
        else if (leave_wr) state_nx = ST_WTR;
      end
      ST_RTW:  if (turn_done) state_nx = ST_WRITE;
      ST_WTR:  if (turn_done) state_nx = ST_READ;
      ST_REF:  state_nx = ST_READ;
      default: state_nx = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_READ;
      tcnt  <= '0;
    end else begin
      state <= state_nx;
      if (state_nx == ST_RTW && state != ST_RTW)      tcnt <= RTW_LOAD;
      else if (state_nx == ST_WTR && state != ST_WTR) tcnt <= WTR_LOAD;
      else if (tcnt != '0)                            tcnt <= tcnt - 1'b1;
    end
  end

  assign want_rd   = in_rd & ccd_open;
  assign want_wr   = in_wr & ccd_open;
  assign want_cmd  = in_rd | in_wr;
  assign want_act  = (in_rd | in_wr) & rrd_open;
  assign ref_ask   = {NBANKS{ref_pending}};
  assign ref_issue = (state == ST_REF);

  phase_steer #(
    .NPHASES(NPHASES), .RD_PHASE(RD_PHASE), .RDCMD_PHASE(RDCMD_PHASE),
    .WR_PHASE(WR_PHASE), .WRCMD_PHASE(WRCMD_PHASE)
  ) u_steer (
    .mode(state), .steer(steer));

  // R2: write mode is entered only out of the read-to-write turnaround
  p_write_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && $past(state) != ST_WRITE) |-> $past(state) == ST_RTW);

  // R3: read mode is entered only from the write-to-read turnaround, a refresh or itself
  p_read_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && $past(state) != ST_READ) |-> ($past(state) == ST_WTR || $past(state) == ST_REF));

  // R5: with reads still pending, read mode is left only after its hold ran out
  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RTW && $past(state) == ST_READ && $past(rd_avail)) |-> $past(rd_exp));

  // R4: with writes still pending, write mode is left only after its hold ran out
  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WTR && $past(state) == ST_WRITE && $past(wr_avail)) |-> $past(wr_exp));

  // R9: a refresh slot follows a cycle in which every bank granted
  p_ref_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |-> $past(ref_pending && (&ref_grant)));

  // R9: the refresh slot lasts one cycle
  p_ref_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |=> !ref_issue);

  // R10: never both column directions at once
  p_dir_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(want_rd && want_wr));

endmodule

// File: tb/rw_turn_sched_bench.sv
module rw_turn_sched_bench;

  localparam int NB     = 4;
  localparam int NPH    = 2;
  localparam int PRD    = 0, PRDC = 1, PWR = 1, PWRC = 0;
  localparam int RLAT   = 5, CWLV = 3, TWTR = 2, TCCD = 3, TRRD = 6;
  localparam int RHOLD  = 32, WHOLD = 16;
  // expected idle lengths, restated from R2/R3
  localparam int N_RTW  = RLAT - 1;
  localparam int N_WTR  = TWTR + (CWLV + NPH - 1) / NPH + TCCD - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_avail = 1'b0, wr_avail = 1'b0, ref_pending = 1'b0;
  logic [NB-1:0] ref_grant = '0;
  logic act_accept = 1'b0, col_accept = 1'b0;
  logic want_rd, want_wr, want_cmd, want_act, ref_issue;
  logic [NB-1:0] ref_ask;
  logic [2*NPH-1:0] steer;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rw_turn_sched #(
    .NBANKS(NB), .NPHASES(NPH), .RD_PHASE(PRD), .RDCMD_PHASE(PRDC),
    .WR_PHASE(PWR), .WRCMD_PHASE(PWRC), .READ_LAT(RLAT), .CWL(CWLV),
    .T_WTR(TWTR), .T_CCD(TCCD), .T_RRD(TRRD), .READ_HOLD(RHOLD), .WRITE_HOLD(WHOLD)
  ) u_rw_turn_sched (
    .clk(clk), .rst_n(rst_n), .rd_avail(rd_avail), .wr_avail(wr_avail),
    .ref_pending(ref_pending), .ref_grant(ref_grant), .act_accept(act_accept),
    .col_accept(col_accept), .want_rd(want_rd), .want_wr(want_wr),
    .want_cmd(want_cmd), .want_act(want_act), .ref_ask(ref_ask),
    .ref_issue(ref_issue), .steer(steer));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // mode codes: 0 idle, 1 read, 2 write, 3 refresh
  function automatic int exp_steer(input int m);
    int v;
    v = 0;
    if (m == 1) begin v |= 2 << (2*PRD); v |= 1 << (2*PRDC); end
    if (m == 2) begin v |= 2 << (2*PWR); v |= 1 << (2*PWRC); end
    if (m == 3) v = 3;
    return v;
  endfunction

  task automatic expect_mode(input string tag, input int m);
    check({tag, " steer"}, int'(steer), exp_steer(m));
    check({tag, " want_rd"}, int'(want_rd), int'(m == 1));
    check({tag, " want_wr"}, int'(want_wr), int'(m == 2));
    check({tag, " want_cmd"}, int'(want_cmd), int'(m == 1 || m == 2));
    check({tag, " want_act"}, int'(want_act), int'(m == 1 || m == 2));
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    rst_n = 1'b1;
    #1;
    expect_mode("R1 reset", 1);
    check("R1 ref_issue", int'(ref_issue), 0);
    check("R1 ref_ask", int'(ref_ask), 0);
  endtask

  task automatic t_read_idle();
    rd_avail = 1'b1;
    for (int i = 0; i < 40; i++) begin
      cyc(); #1;
      expect_mode("R11 read kept", 1);
    end
  endtask

  // first exit from read: hold starts expired (R5), then turnaround (R2)
  task automatic t_rtw_first();
    cyc(); wr_avail = 1'b1; #1;
    expect_mode("R5 first exit last read", 1);
    for (int i = 0; i < N_RTW; i++) begin
      cyc(); #1;
      expect_mode("R2 rtw idle", 0);
    end
    cyc(); #1;
    expect_mode("R2 write reached", 2);
  endtask

  task automatic t_write_hold();
    for (int i = 1; i < WHOLD; i++) begin
      cyc(); #1;
      expect_mode("R4 write held", 2);
    end
    for (int i = 0; i < N_WTR; i++) begin
      cyc(); #1;
      expect_mode("R3 wtr idle", 0);
    end
    cyc(); #1;
    expect_mode("R3 read reached", 1);
  endtask

  task automatic t_read_hold();
    for (int i = 1; i < RHOLD; i++) begin
      cyc(); #1;
      expect_mode("R5 read held", 1);
    end
    for (int i = 0; i < N_RTW; i++) begin
      cyc(); #1;
      expect_mode("R2 rtw idle after hold", 0);
    end
    cyc(); #1;
    expect_mode("R10 write mode", 2);
  endtask

  task automatic t_write_idle();
    rd_avail = 1'b0;
    for (int i = 0; i < 30; i++) begin
      cyc(); #1;
      expect_mode("R11 write kept", 2);
    end
    cyc(); rd_avail = 1'b1; wr_avail = 1'b0; #1;
    expect_mode("R11 write last", 2);
    for (int i = 0; i < N_WTR; i++) begin
      cyc(); #1;
      expect_mode("R3 wtr idle no writes", 0);
    end
    cyc(); #1;
    expect_mode("R3 read back", 1);
  endtask

  task automatic t_rrd();
    cyc(); act_accept = 1'b1; #1;
    check("R6 act open before", int'(want_act), 1);
    for (int i = 1; i <= TRRD; i++) begin
      cyc(); act_accept = 1'b0; #1;
      check("R6 act spacing", int'(want_act), int'(i == TRRD));
    end
  endtask

  task automatic t_ccd();
    cyc(); col_accept = 1'b1; #1;
    check("R7 col open before", int'(want_rd), 1);
    for (int i = 1; i <= TCCD; i++) begin
      cyc(); col_accept = 1'b0; #1;
      check("R7 col spacing", int'(want_rd), int'(i == TCCD));
    end
  endtask

  task automatic t_refresh();
    cyc(); ref_pending = 1'b1; #1;
    check("R8 ask raised", int'(ref_ask), (1 << NB) - 1);
    check("R9 no slot yet", int'(ref_issue), 0);
    for (int b = 0; b < NB; b++) begin
      cyc(); ref_grant[b] = 1'b1; #1;
      check("R9 waits for grants", int'(ref_issue), 0);
      expect_mode("R9 mode unchanged", 1);
    end
    cyc(); #1;
    check("R9 slot open", int'(ref_issue), 1);
    expect_mode("R9 refresh steer", 3);
    ref_pending = 1'b0; ref_grant = '0; #1;
    check("R8 ask dropped", int'(ref_ask), 0);
    cyc(); #1;
    check("R9 slot one cycle", int'(ref_issue), 0);
    expect_mode("R9 back to read", 1);
  endtask

  initial begin
    t_reset();
    t_read_idle();
    t_rtw_first();
    t_write_hold();
    t_read_hold();
    t_write_idle();
    t_rrd();
    t_ccd();
    t_refresh();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule